// File: doc/BRIEF.md
# A/D Trigger and Conversion Sequencer

This block decides when the analog-to-digital converter of an acquisition card runs, and when each result goes to the sample FIFO. Software programs a small set of write-only registers over a simple address/data write port. A control register picks where conversion requests come from: software, rising edges on an external pacer line, or pulses from an internal pacer counter.

A write to the start offset opens an acquisition gate. While the gate is open, each qualified request starts a sequence. The sequence counts pulses from a free-running 1 MHz tick. The first counted tick produces the convert strobe. The third produces the FIFO write strobe. This holds the delay from a software start to the first stored sample to at most three tick periods.

Acquisition ends in one of three ways:
- a write to the stop offset;
- a falling edge on the external gate line, in either paced mode;
- reaching the programmed channel count, when burst operation is on.

A paced request that arrives while a sequence is still running is dropped, and a sticky overrun flag records it.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset the gate, the convert strobe, the FIFO write strobe and the overrun flag are all low, and the trigger source is software, so a start write alone produces conversions.
- R2: The trigger source is bits [1:0] of the control register at offset 2. If bit 1 is 0, the mode is software, whatever bit 0 holds. Value 2 selects rising edges of the external pacer line. Value 3 selects internal pacer pulses. Each paced mode ignores the other mode's request source.
- R3: Once a sequence is running, the convert strobe is a one-cycle pulse one clock after the first counted tick. The FIFO write strobe is a one-cycle pulse one clock after the third counted tick, so it follows the convert strobe by exactly two tick periods. The two strobes never coincide.
- R4: In software mode, a write to offset 0 opens the gate on the next clock. The first FIFO write strobe follows the clock edge that takes that write by at least 2P+2 and at most 3P+1 clock edges, where P is the tick period in clocks. The gate opens only through such a write.
- R5: A write to offset 9 closes the gate on the next clock, aborts any running sequence so no further strobe follows, and clears the overrun flag.
- R6: In external mode, each synchronized rising edge of the external pacer line starts one conversion. In either paced mode, a falling edge of the external gate line closes the gate; the line's rising edge and the pacer line's falling edge have no effect.
- R7: In a paced mode, a request that arrives while a sequence is running produces no extra FIFO write, and it sets the overrun flag. The flag stays high until a stop write.
- R8: With burst enable (bit 2 of the control register) set, the gate closes after as many FIFO writes as the channel count written at offset 0xA. A count of N gives exactly N writes.
- R9: Writes to offsets other than 0, 2, 9 and 0xA neither open the gate nor change the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register offset of the write |
| wr_data_i | input | DATA_W | Write data |
| tick_i | input | 1 | Free-running 1 MHz pulse, one clock wide |
| pacer_i | input | 1 | Internal pacer pulse, one clock wide |
| ext_pacer_i | input | 1 | Asynchronous external pacer line |
| ext_gate_i | input | 1 | Asynchronous external trigger/gate line |
| gate_o | output | 1 | Acquisition gate open |
| conv_o | output | 1 | Convert strobe |
| fifo_wr_o | output | 1 | FIFO write strobe |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench starts software acquisition at every phase of the tick. A design that counted the tick already present at the start edge, or that waited for a fourth pulse, would land outside the latency window. A gap other than two tick periods between the convert and write strobes would show a wrong pulse count.

Paced requests are sent during a running sequence. A design that restarted the sequence or missed the flag would then give an extra FIFO write or a low overrun flag. The external pacer line is also held high, which would repeat conversions in a design that acted on level instead of edge.

Burst runs sweep the channel count from one to four. An off-by-one comparison shows up there as one write too many or too few. A stop write is placed in the middle of a sequence. A design that only closed the gate there would let a late strobe through.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    MODE_SW  = 2'd0,
    MODE_EXT = 2'd1,
    MODE_INT = 2'd2
  } trig_mode_e;

  localparam int unsigned OFS_START = 0;
  localparam int unsigned OFS_CTRL  = 2;
  localparam int unsigned OFS_STOP  = 9;
  localparam int unsigned OFS_BLEN  = 10;

  // src[1] low: software regardless of src[0]
  function automatic trig_mode_e decode_src(input logic [1:0] src);
    if (!src[1]) return MODE_SW;
    if (!src[0]) return MODE_EXT;
    return MODE_INT;
  endfunction

endpackage

// File: rtl/adc_trig_regs.sv
module adc_trig_regs
  import adc_trig_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output trig_mode_e        mode_o,
  output logic              burst_en_o,
  output logic [CNT_W-1:0]  burst_len_o,
  output logic              start_o,
  output logic              stop_o
);

  logic [1:0]       src_q;
  logic             burst_q;
  logic [CNT_W-1:0] len_q;
  logic             ctrl_we, len_we;

  always_comb begin
    start_o = wr_en_i && (wr_addr_i == ADDR_W'(OFS_START));
    stop_o  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_STOP));
    ctrl_we = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CTRL));
    len_we  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_BLEN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= 2'b00;
      burst_q <= 1'b0;
      len_q   <= '0;
    end else begin
      if (ctrl_we) begin
        src_q   <= wr_data_i[1:0];
        burst_q <= wr_data_i[2];
      end
      if (len_we) len_q <= CNT_W'(wr_data_i);
    end
  end

  assign mode_o      = decode_src(src_q);
  assign burst_en_o  = burst_q;
  assign burst_len_o = len_q;

endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic edge_o
);

  // STAGES flops of synchronizer plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    end else begin : g_fall
      assign edge_o = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
  endgenerate

endmodule

// File: rtl/adc_trig_core.sv
module adc_trig_core
  import adc_trig_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PULSES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ext_rise_i,
  input  logic             ext_fall_i,
  input  logic             pacer_i,
  input  trig_mode_e       mode_i,
  input  logic             burst_en_i,
  input  logic [CNT_W-1:0] burst_len_i,
  output logic             gate_o,
  output logic             conv_o,
  output logic             fifo_wr_o,
  output logic             overrun_o
);

  localparam int unsigned     PW   = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [PW-1:0]   LAST = PW'(PULSES - 1);

  logic             gate_q, busy_q, conv_q, fifo_q, ovr_q;
  logic [PW-1:0]    pcnt_q;
  logic [CNT_W-1:0] chan_q;
  logic             paced, req, hit, first, last, abort, burst_done;

  always_comb begin
    paced = (mode_i != MODE_SW);
    case (mode_i)
      MODE_SW:  req = gate_q & ~busy_q;   // self-repeating
      MODE_EXT: req = gate_q & ext_rise_i;
      default:  req = gate_q & pacer_i;
    endcase
    hit        = busy_q & tick_i;
    first      = hit & (pcnt_q == '0);
    last       = hit & (pcnt_q == LAST);
    abort      = stop_i | (paced & ext_fall_i);
    burst_done = last & burst_en_i & ((chan_q + CNT_W'(1)) == burst_len_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      busy_q <= 1'b0;
      pcnt_q <= '0;
      chan_q <= '0;
      conv_q <= 1'b0;
      fifo_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      conv_q <= first & ~abort;
      fifo_q <= last & ~abort;

      if (abort)           gate_q <= 1'b0;
      else if (start_i)    gate_q <= 1'b1;
      else if (burst_done) gate_q <= 1'b0;

      if (abort | last) begin
        busy_q <= 1'b0;
        pcnt_q <= '0;
      end else if (hit) begin
        pcnt_q <= pcnt_q + PW'(1);
      end else if (req) begin
        busy_q <= 1'b1;
      end

      if (start_i)            chan_q <= '0;
      else if (last & ~abort) chan_q <= chan_q + CNT_W'(1);

      if (stop_i)                       ovr_q <= 1'b0;
      else if (paced & req & busy_q)    ovr_q <= 1'b1;
    end
  end

  assign gate_o    = gate_q;
  assign conv_o    = conv_q;
  assign fifo_wr_o = fifo_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PULSES      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  input  logic              pacer_i,
  input  logic              ext_pacer_i,
  input  logic              ext_gate_i,
  output logic              gate_o,
  output logic              conv_o,
  output logic              fifo_wr_o,
  output logic              overrun_o
);

  trig_mode_e       mode;
  logic             burst_en, start, stop, ext_rise, ext_fall;
  logic [CNT_W-1:0] burst_len;

  adc_trig_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .mode_o     (mode),
    .burst_en_o (burst_en),
    .burst_len_o(burst_len),
    .start_o    (start),
    .stop_o     (stop)
  );

  adc_trig_sync #(.STAGES(SYNC_STAGES), .RISING(1'b1)) u_pacer_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_pacer_i),
    .edge_o (ext_rise)
  );

  adc_trig_sync #(.STAGES(SYNC_STAGES), .RISING(1'b0)) u_gate_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_gate_i),
    .edge_o (ext_fall)
  );

  adc_trig_core #(.CNT_W(CNT_W), .PULSES(PULSES)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .start_i    (start),
    .stop_i     (stop),
    .ext_rise_i (ext_rise),
    .ext_fall_i (ext_fall),
    .pacer_i    (pacer_i),
    .mode_i     (mode),
    .burst_en_i (burst_en),
    .burst_len_i(burst_len),
    .gate_o     (gate_o),
    .conv_o     (conv_o),
    .fifo_wr_o  (fifo_wr_o),
    .overrun_o  (overrun_o)
  );

endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk
  import adc_trig_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              gate_o,
  input logic              conv_o,
  input logic              fifo_wr_o,
  input logic              overrun_o
);

  logic start_w, stop_w;
  assign start_w = wr_en_i && (wr_addr_i == ADDR_W'(OFS_START));
  assign stop_w  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_STOP));

  // R5
  stop_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (!gate_o && !overrun_o));

  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_o && fifo_wr_o));

  // R3
  conv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o);

  // R4
  gate_open_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(start_w));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_o |=> (!conv_o && !fifo_wr_o));

  // R7
  overrun_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !stop_w) |=> overrun_o);

endmodule

bind adc_trig_seq adc_trig_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .gate_o   (gate_o),
  .conv_o   (conv_o),
  .fifo_wr_o(fifo_wr_o),
  .overrun_o(overrun_o)
);

// File: tb/sim_adc_trig_seq.sv
module sim_adc_trig_seq;

  localparam int CLK_P  = 10;
  localparam int TICK_P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic       pacer = 1'b0;
  logic       ext_pacer = 1'b0;
  logic       ext_gate = 1'b1;
  logic       gate_o, conv_o, fifo_wr_o, overrun_o;

  int n_chk = 0, n_err = 0, conv_cnt = 0, fifo_cnt = 0;
  bit done = 1'b0;

  adc_trig_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .pacer_i(pacer),
    .ext_pacer_i(ext_pacer), .ext_gate_i(ext_gate), .gate_o(gate_o),
    .conv_o(conv_o), .fifo_wr_o(fifo_wr_o), .overrun_o(overrun_o)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % TICK_P;
      tick = (ph == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (conv_o) conv_cnt++;
    if (fifo_wr_o) fifo_cnt++;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic bus_wr(input int a, input int d);
    cyc();
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic pace();
    cyc(); pacer = 1'b1;
    cyc(); pacer = 1'b0;
  endtask

  task automatic clr();
    conv_cnt = 0; fifo_cnt = 0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    int n, nc;
    step(3);
    rst_n = 1'b1;
    cyc();
    // R1: reset state
    check(gate_o == 0, "R1 gate", gate_o, 0);
    check(conv_o == 0, "R1 conv", conv_o, 0);
    check(fifo_wr_o == 0, "R1 fifo_wr", fifo_wr_o, 0);
    check(overrun_o == 0, "R1 overrun", overrun_o, 0);

    // R4/R3: latency sweep over every tick phase, software mode from reset (R1)
    for (int p = 0; p < TICK_P; p++) begin
      step(p);
      bus_wr(0, 0);
      check(gate_o == 1, "R4 gate opens", gate_o, 1);
      n = 0; nc = -1;
      while (!fifo_wr_o && n < 100) begin
        if (conv_o && nc < 0) nc = n;
        @(negedge clk); n++;
      end
      check(n >= 2*TICK_P + 2 && n <= 3*TICK_P + 1, "R4 latency", n, 3*TICK_P + 1);
      check(n - nc == 2*TICK_P, "R3 conv to fifo gap", n - nc, 2*TICK_P);
      bus_wr(9, 0);
      step(2);
    end

    // R5: stop in mid-sequence aborts
    bus_wr(0, 0);
    step(2*TICK_P + 3);
    bus_wr(9, 0);
    check(gate_o == 0, "R5 gate closed", gate_o, 1'b0);
    clr(); step(30);
    check(fifo_cnt == 0, "R5 no write after stop", fifo_cnt, 0);
    check(conv_cnt == 0, "R5 no convert after stop", conv_cnt, 0);

    // R2: source 1 behaves as software
    bus_wr(2, 1);
    clr(); bus_wr(0, 0); step(40);
    check(fifo_cnt >= 2, "R2 src=1 software repeat", fifo_cnt, 2);
    bus_wr(9, 0);

    // R2/R7: internal pacer mode
    bus_wr(2, 3);
    bus_wr(0, 0);
    clr(); step(20);
    check(fifo_cnt == 0, "R2 internal idle", fifo_cnt, 0);
    ext_pacer = 1'b1; clr(); step(20); ext_pacer = 1'b0; step(4);
    check(fifo_cnt == 0, "R2 internal ignores ext edge", fifo_cnt, 0);
    clr(); pace(); step(20);
    check(fifo_cnt == 1, "R2 internal one pulse", fifo_cnt, 1);
    check(overrun_o == 0, "R7 no overrun", overrun_o, 0);
    clr(); pace(); step(2); pace(); cyc();
    check(overrun_o == 1, "R7 overrun set", overrun_o, 1);
    step(20);
    check(fifo_cnt == 1, "R7 dropped request", fifo_cnt, 1);
    check(overrun_o == 1, "R7 overrun sticky", overrun_o, 1);
    bus_wr(9, 0);
    check(overrun_o == 0, "R5 overrun cleared", overrun_o, 0);

    // R2/R6: external pacer mode
    bus_wr(2, 2);
    bus_wr(0, 0);
    clr(); pace(); step(20);
    check(fifo_cnt == 0, "R2 external ignores pacer", fifo_cnt, 0);
    clr(); ext_pacer = 1'b1; step(30);
    check(fifo_cnt == 1, "R6 one write per edge", fifo_cnt, 1);
    clr(); ext_pacer = 1'b0; step(20);
    check(fifo_cnt == 0, "R6 falling pacer ignored", fifo_cnt, 0);
    ext_gate = 1'b0; step(6);
    check(gate_o == 0, "R6 gate fall closes", gate_o, 0);
    ext_gate = 1'b1; step(6);
    check(gate_o == 0, "R6 gate rise ignored", gate_o, 0);

    // R8: burst counts
    for (int nb = 1; nb <= 4; nb++) begin
      bus_wr(2, 4);
      bus_wr(10, nb);
      clr(); bus_wr(0, 0);
      n = 0;
      while (gate_o && n < 300) begin cyc(); n++; end
      step(10);
      check(fifo_cnt == nb, "R8 burst writes", fifo_cnt, nb);
      check(gate_o == 0, "R8 gate closed", gate_o, 0);
      bus_wr(9, 0);
    end

    // R9: other offsets inert
    bus_wr(2, 0);
    clr();
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 2 && a != 9 && a != 10) bus_wr(a, 8'hFF);
    end
    step(20);
    check(gate_o == 0, "R9 gate stays closed", gate_o, 0);
    check(fifo_cnt == 0, "R9 no conversions", fifo_cnt, 0);
    bus_wr(0, 0);
    n = 0;
    while (!fifo_wr_o && n < 100) begin @(negedge clk); n++; end
    check(n <= 3*TICK_P + 1, "R9 config unchanged", n, 3*TICK_P + 1);
    bus_wr(9, 0);

    report();
  end

endmodule